// File: doc/BRIEF.md
# Bidirectional Port Register File with Pin-Change Interrupt

This block holds the register state behind two 8-bit general-purpose ports. Each pin has three settings: an output latch, a readback inversion mask and a direction bit. The block drives per-pin output data and output enables. It brings the pin levels in through a synchronizer and returns them through the register read path, with the inversion mask applied.

A bus front end reaches the registers through a small indexed interface. The interface has a register index, a write strobe with write data, and a read strobe with registered read data. Every read of a port's input register stores a snapshot of that port's synchronized pins. An active-low interrupt line goes low while any pin that is configured as an input differs from its snapshot. The line releases when the pin returns to the snapshot value or when the port is read again. The interrupt is a registered level, meant to feed an open-drain pad driver.

Top module: `gpio_port_regs`

## Requirements
- R1: Reset (synchronous, active high) sets every pin as an input: `pin_oe` is all zeros. It sets `pin_out` to all ones, the readback masks to zero and `irq_n` to 1. Reads then return FF for the output and direction registers and 00 for the mask registers.
- R2: `reg_idx[0]` selects the port (0 = pins 7..0, 1 = pins 15..8). `reg_idx[2:1]` selects the register: 0 = input, 1 = output latch, 2 = readback mask, 3 = direction. `rd_data` is loaded on the clock edge that samples `rd_en` and holds its value until the next read.
- R3: A write updates the selected output, mask or direction register on the sampling edge. A write to an input index changes nothing.
- R4: `pin_oe` bit n is the inverse of direction bit n: a 1 means input and turns the driver off. `pin_out` always shows the output latches, whatever the direction.
- R5: An input register read returns the synchronized pin levels XOR the port's mask. A pin change reaches the read path after two clock edges.
- R6: An input-configured pin that differs from its snapshot drives `irq_n` low on the third clock edge after the pin changes.
- R7: A read of a port's input register loads that port's snapshot only. `irq_n` returns high on the next edge if no other input pin differs from its snapshot.
- R8: With no read, `irq_n` returns high once the pins match their snapshot again.
- R9: Pins whose direction bit is 0 never cause an interrupt.
- R10: For the first three clock edges after reset, the snapshot follows the synchronized pins and `irq_n` stays high.
- R11: When a read and a write hit the same register in one cycle, the read returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_idx | input | 3 | Register index: kind in bits 2:1, port in bit 0 |
| wr_en | input | 1 | Write strobe, one cycle |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe, one cycle |
| rd_data | output | 8 | Registered read data |
| pin_in | input | 16 | Pin levels from the pads, asynchronous |
| pin_out | output | 16 | Output latch values to the pads |
| pin_oe | output | 16 | Pad driver enables, 1 = drive |
| irq_n | output | 1 | Change interrupt, active low |

## Verification
The assertions assume three things about the front end. Each strobe lasts one cycle. The register index is valid whenever a strobe is high. Each pin holds a level long enough to pass through both synchronizer stages. The stimulus meets these conditions: it changes pins and strobes only on falling edges, and it keeps every pin level for at least one full cycle. The interrupt checks also assume the pins are held still during reset and during the settle window, and the stimulus keeps them still there, so the first snapshot is well defined.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  typedef enum logic [1:0] {
    KIND_INPUT    = 2'd0,
    KIND_OUTPUT   = 2'd1,
    KIND_POLARITY = 2'd2,
    KIND_CONFIG   = 2'd3
  } reg_kind_e;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W      = 16,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_port_bank.sv
module gpio_port_bank
  import gpio_pkg::*;
#(
  parameter int PORT_W    = 8,
  parameter int NUM_PORTS = 2,
  localparam int PSEL_W   = $clog2(NUM_PORTS),
  localparam int IDX_W    = PSEL_W + 2,
  localparam int TOTAL    = PORT_W * NUM_PORTS
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [IDX_W-1:0]     reg_idx,
  input  logic                 wr_en,
  input  logic [PORT_W-1:0]    wr_data,
  input  logic                 rd_en,
  input  logic [TOTAL-1:0]     pin_sync,
  output logic [PORT_W-1:0]    rd_data,
  output logic [TOTAL-1:0]     pin_out,
  output logic [TOTAL-1:0]     cfg_out,
  output logic [NUM_PORTS-1:0] snap_ld
);
  reg_kind_e         kind;
  logic [PSEL_W-1:0] psel;
  logic [PORT_W-1:0] out_q [NUM_PORTS];
  logic [PORT_W-1:0] pol_q [NUM_PORTS];
  logic [PORT_W-1:0] cfg_q [NUM_PORTS];
  logic [TOTAL-1:0]  pol_flat;
  logic [PORT_W-1:0] rd_mux;

  assign kind = reg_kind_e'(reg_idx[IDX_W-1 -: 2]);
  assign psel = reg_idx[PSEL_W-1:0];

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic hit;
    assign hit = wr_en && (psel == PSEL_W'(p));

    always_ff @(posedge clk) begin
      if (rst) begin
        out_q[p] <= '1;
        pol_q[p] <= '0;
        cfg_q[p] <= '1;
      end else if (hit) begin
        case (kind)
          KIND_OUTPUT:   out_q[p] <= wr_data;
          KIND_POLARITY: pol_q[p] <= wr_data;
          KIND_CONFIG:   cfg_q[p] <= wr_data;
          default:       ;
        endcase
      end
    end

    assign pin_out[p*PORT_W +: PORT_W]  = out_q[p];
    assign cfg_out[p*PORT_W +: PORT_W]  = cfg_q[p];
    assign pol_flat[p*PORT_W +: PORT_W] = pol_q[p];
    assign snap_ld[p] = rd_en && (kind == KIND_INPUT) && (psel == PSEL_W'(p));
  end

  always_comb begin
    case (kind)
      KIND_INPUT:    rd_mux = pin_sync[int'(psel)*PORT_W +: PORT_W] ^ pol_q[psel];
      KIND_OUTPUT:   rd_mux = out_q[psel];
      KIND_POLARITY: rd_mux = pol_q[psel];
      default:       rd_mux = cfg_q[psel];
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= rd_mux;
  end

  // R2: read data holds between reads
  a_r2_rd_hold: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));

  // R3: writes aimed at an input index leave every register unchanged
  a_r3_input_write_ignored: assert property (@(posedge clk) disable iff (rst)
    (wr_en && kind == KIND_INPUT) |=>
      ($stable(pin_out) && $stable(cfg_out) && $stable(pol_flat)));
endmodule

// File: rtl/gpio_change_irq.sv
module gpio_change_irq #(
  parameter int PORT_W    = 8,
  parameter int NUM_PORTS = 2,
  parameter int STAGES    = 2,
  localparam int TOTAL    = PORT_W * NUM_PORTS,
  localparam int CW       = $clog2(STAGES + 2)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [TOTAL-1:0]     pin_sync,
  input  logic [TOTAL-1:0]     in_mask,
  input  logic [NUM_PORTS-1:0] snap_ld,
  output logic                 irq_n
);
  logic [CW-1:0]     settle_cnt;
  logic              settling;
  logic [PORT_W-1:0] snap_q [NUM_PORTS];
  logic [TOTAL-1:0]  snap_flat;
  logic [TOTAL-1:0]  diff;

  assign settling = (settle_cnt != '0);

  always_ff @(posedge clk) begin
    if (rst)           settle_cnt <= CW'(STAGES + 1);
    else if (settling) settle_cnt <= settle_cnt - 1'b1;
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_snap
    always_ff @(posedge clk) begin
      if (rst)
        snap_q[p] <= '0;
      else if (settling || snap_ld[p])
        snap_q[p] <= pin_sync[p*PORT_W +: PORT_W];
    end
    assign snap_flat[p*PORT_W +: PORT_W] = snap_q[p];
  end

  assign diff = (pin_sync ^ snap_flat) & in_mask;

  always_ff @(posedge clk) begin
    if (rst || settling) irq_n <= 1'b1;
    else                 irq_n <= ~|diff;
  end

  // R10: no interrupt during the settle window
  a_r10_quiet_settle: assert property (@(posedge clk) disable iff (rst)
    settling |=> irq_n);

  // R9: with every pin an output the line stays released
  a_r9_outputs_excluded: assert property (@(posedge clk) disable iff (rst)
    (in_mask == '0) |=> irq_n);

  // R8: no new interrupt without a change of pins, direction or snapshot
  a_r8_no_spurious_irq: assert property (@(posedge clk) disable iff (rst)
    (irq_n && !$past(rst) && !$past(settling) && $past(snap_ld) == '0 &&
     $stable(pin_sync) && $stable(in_mask)) |=> irq_n);
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs #(
  parameter int PORT_W      = 8,
  parameter int NUM_PORTS   = 2,
  parameter int SYNC_STAGES = 2,
  localparam int PSEL_W     = $clog2(NUM_PORTS),
  localparam int IDX_W      = PSEL_W + 2,
  localparam int TOTAL      = PORT_W * NUM_PORTS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  reg_idx,
  input  logic              wr_en,
  input  logic [PORT_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [PORT_W-1:0] rd_data,
  input  logic [TOTAL-1:0]  pin_in,
  output logic [TOTAL-1:0]  pin_out,
  output logic [TOTAL-1:0]  pin_oe,
  output logic              irq_n
);
  logic [TOTAL-1:0]     pin_sync;
  logic [TOTAL-1:0]     cfg;
  logic [NUM_PORTS-1:0] snap_ld;

  gpio_in_sync #(.W(TOTAL), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pin_in),
    .q   (pin_sync)
  );

  gpio_port_bank #(.PORT_W(PORT_W), .NUM_PORTS(NUM_PORTS)) u_bank (
    .clk      (clk),
    .rst      (rst),
    .reg_idx  (reg_idx),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .rd_en    (rd_en),
    .pin_sync (pin_sync),
    .rd_data  (rd_data),
    .pin_out  (pin_out),
    .cfg_out  (cfg),
    .snap_ld  (snap_ld)
  );

  gpio_change_irq #(.PORT_W(PORT_W), .NUM_PORTS(NUM_PORTS), .STAGES(SYNC_STAGES)) u_irq (
    .clk      (clk),
    .rst      (rst),
    .pin_sync (pin_sync),
    .in_mask  (cfg),
    .snap_ld  (snap_ld),
    .irq_n    (irq_n)
  );

  assign pin_oe = ~cfg;

  // R1: state right after reset
  a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (irq_n && pin_oe == '0 && pin_out == '1));
endmodule

// File: tb/sim_gpio_port_regs.sv
`timescale 1ns/1ps
module sim_gpio_port_regs;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  reg_idx = '0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_data = '0;
  logic        rd_en = 1'b0;
  logic [7:0]  rd_data;
  logic [15:0] pin_in = 16'hA55A;
  logic [15:0] pin_out, pin_oe;
  logic        irq_n;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;
  bit model_on = 0;
  bit done     = 0;

  always #10 clk = ~clk;

  gpio_port_regs u0 (
    .clk(clk), .rst(rst), .reg_idx(reg_idx), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .irq_n(irq_n)
  );

  // behavioural reference
  logic [15:0] m_s1, m_s2, m_snap, m_out, m_pol, m_cfg;
  logic [7:0]  m_rd;
  logic        m_irqn;
  int          m_settle;

  always @(posedge clk) begin
    logic [15:0] n_snap, n_out, n_pol, n_cfg, live;
    logic [7:0]  n_rd;
    logic        n_irqn;
    int          sh;
    model_on <= 1;
    if (rst) begin
      m_s1 = 0; m_s2 = 0; m_snap = 0; m_out = 16'hFFFF; m_pol = 0;
      m_cfg = 16'hFFFF; m_rd = 0; m_irqn = 1; m_settle = 3;
    end else begin
      sh = reg_idx[0] ? 8 : 0;
      n_irqn = (m_settle != 0) ? 1'b1 : (((m_s2 ^ m_snap) & m_cfg) == 16'h0);
      n_snap = m_snap;
      if (m_settle != 0) n_snap = m_s2;
      else if (rd_en && reg_idx[2:1] == 2'd0)
        for (int b = 0; b < 8; b++) n_snap[sh+b] = m_s2[sh+b];
      live = m_s2 ^ m_pol;
      n_rd = m_rd;
      if (rd_en)
        case (reg_idx[2:1])
          2'd0: n_rd = live[sh +: 8];
          2'd1: n_rd = m_out[sh +: 8];
          2'd2: n_rd = m_pol[sh +: 8];
          default: n_rd = m_cfg[sh +: 8];
        endcase
      n_out = m_out; n_pol = m_pol; n_cfg = m_cfg;
      if (wr_en)
        case (reg_idx[2:1])
          2'd1: n_out[sh +: 8] = wr_data;
          2'd2: n_pol[sh +: 8] = wr_data;
          2'd3: n_cfg[sh +: 8] = wr_data;
          default: ;
        endcase
      m_s2 = m_s1; m_s1 = pin_in;
      m_snap = n_snap; m_rd = n_rd; m_irqn = n_irqn;
      m_out = n_out; m_pol = n_pol; m_cfg = n_cfg;
      if (m_settle != 0) m_settle--;
    end
  end

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h at cycle %0d", req, got, exp, cycles);
    end
  endtask

  // per-cycle comparison against the reference, away from the active edge
  always @(negedge clk) begin
    cycles++;
    if (model_on && !done) begin
      check("R4 pin_out", {16'h0, pin_out}, {16'h0, m_out});
      check("R4 pin_oe", {16'h0, pin_oe}, {16'h0, ~m_cfg});
      check("R6 irq_n", {31'h0, irq_n}, {31'h0, m_irqn});
      check("R2 rd_data", {24'h0, rd_data}, {24'h0, m_rd});
    end
  end

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  task automatic do_write(logic [2:0] idx, logic [7:0] d);
    @(negedge clk); reg_idx = idx; wr_data = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic do_read(logic [2:0] idx);
    @(negedge clk); reg_idx = idx; rd_en = 1;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [31:0] lfsr = 32'hACE1_2468;
    repeat (4) @(negedge clk);
    rst = 0;
    // R10: the line stays high through the settle window
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R10 settle irq_n", {31'h0, irq_n}, 32'h1);
    end
    idle(2);
    // R1: reset state
    check("R1 pin_oe", {16'h0, pin_oe}, 32'h0);
    check("R1 pin_out", {16'h0, pin_out}, 32'hFFFF);
    check("R1 irq_n", {31'h0, irq_n}, 32'h1);
    do_read(3'd2); check("R1 out0", {24'h0, rd_data}, 32'hFF);
    do_read(3'd4); check("R1 pol0", {24'h0, rd_data}, 32'h00);
    do_read(3'd7); check("R1 cfg1", {24'h0, rd_data}, 32'hFF);
    // R5: input readback
    do_read(3'd0); check("R5 in0", {24'h0, rd_data}, 32'h5A);
    do_read(3'd1); check("R5 in1", {24'h0, rd_data}, 32'hA5);
    // R2: data holds with no read
    idle(3); check("R2 hold", {24'h0, rd_data}, 32'hA5);
    // R5 with mask, R3 input write ignored
    do_write(3'd4, 8'h0F);
    do_read(3'd0); check("R5 masked in0", {24'h0, rd_data}, 32'h55);
    do_write(3'd0, 8'h00);
    check("R3 pin_out after input write", {16'h0, pin_out}, 32'hFFFF);
    do_read(3'd0); check("R3 in0 unchanged", {24'h0, rd_data}, 32'h55);
    do_read(3'd4); check("R3 pol0 unchanged", {24'h0, rd_data}, 32'h0F);
    // R4: direction and latch
    do_write(3'd6, 8'hF0);
    do_write(3'd2, 8'h3C);
    check("R4 oe", {16'h0, pin_oe}, 32'h000F);
    check("R4 out", {16'h0, pin_out}, 32'hFF3C);
    // R6: port1 pin change, three edges to the line
    do_read(3'd0); do_read(3'd1);
    idle(1);
    pin_in = pin_in ^ 16'h1000;
    idle(2); check("R6 before third edge", {31'h0, irq_n}, 32'h1);
    idle(1); check("R6 asserted", {31'h0, irq_n}, 32'h0);
    // R7: other port's read leaves it low, own port read clears it
    do_read(3'd0); idle(1); check("R7 other port", {31'h0, irq_n}, 32'h0);
    do_read(3'd1); check("R7 before clear", {31'h0, irq_n}, 32'h0);
    idle(1); check("R7 cleared", {31'h0, irq_n}, 32'h1);
    // R8: pin returns to the snapshot
    pin_in = pin_in ^ 16'h0020;
    idle(3); check("R8 asserted", {31'h0, irq_n}, 32'h0);
    pin_in = pin_in ^ 16'h0020;
    idle(3); check("R8 released", {31'h0, irq_n}, 32'h1);
    // R9: output pin changes are ignored
    pin_in = pin_in ^ 16'h0002;
    idle(5); check("R9 output pin", {31'h0, irq_n}, 32'h1);
    // R11: read and write together
    @(negedge clk); reg_idx = 3'd3; wr_data = 8'h12; wr_en = 1; rd_en = 1;
    @(negedge clk); wr_en = 0; rd_en = 0;
    check("R11 old value", {24'h0, rd_data}, 32'hFF);
    do_read(3'd3); check("R11 new value", {24'h0, rd_data}, 32'h12);
    // port 1 mask
    do_write(3'd5, 8'hFF);
    do_read(3'd1); check("R5 masked in1", {24'h0, rd_data}, {24'h0, ~pin_in[15:8]});
    // mixed traffic against the reference
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      wr_en = 0; rd_en = 0;
      if (lfsr[3:0] == 4'h0) pin_in = pin_in ^ (16'h1 << lfsr[11:8]);
      reg_idx = lfsr[14:12];
      wr_data = lfsr[23:16];
      wr_en = lfsr[26:24] == 3'd0;
      rd_en = lfsr[29:27] < 3'd3;
    end
    @(negedge clk); wr_en = 0; rd_en = 0;
    idle(4);
    finish_run();
  end
endmodule